// File: doc/BRIEF.md
# Armed Door Alarm Controller

This block watches a three-bit vector, made of one arming bit and two sensor bits, and drives a siren. It has two states. While idle the siren is off. When the system is armed and at least one sensor reports a disturbance, the block enters the alarm state and the siren sounds. From then on the siren keeps sounding for as long as the arming bit stays set, even if the sensors go back to rest. Clearing the arming bit silences it.

The input vector passes through one register stage before the state logic sees it. Every transition, into the alarm state or back to idle, must be qualified. The condition has to hold on the registered input for `QUAL_CYC` consecutive cycles, 8 by default. A single cycle without the condition restarts the count. The siren output and a one-bit state indicator are both registered, so they change on the same clock edge.

Top module: `door_alarm_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first sample after its release, `alarm_state` is 0 and `siren` is 0. Reset is asynchronous.
- R2: `siren` equals `alarm_state` in every cycle.
- R3: From idle, any input with `sense[2]` = 0, or with `sense[1:0]` = 00 (values 0, 1, 2, 3 and 4), leaves the block idle and the siren off, no matter how long that input is held.
- R4: From idle, an input with `sense[2]` = 1 and `sense[1:0]` ≠ 00 (values 5, 6 and 7), held at the port, makes `alarm_state` and `siren` rise on the (`QUAL_CYC`+1)-th rising edge after it is applied, and not earlier.
- R5: If the qualifying condition fails for one registered cycle before `QUAL_CYC` consecutive cycles are complete, the count restarts and no transition takes place.
- R6: In the alarm state, any input with `sense[2]` = 1, including 100 (sensors at rest), keeps the block in alarm with the siren on.
- R7: In the alarm state, an input with `sense[2]` = 0 held at the port returns the block to idle (`alarm_state` = 0, `siren` = 0) on the (`QUAL_CYC`+1)-th rising edge after it is applied.
- R8: `alarm_state` reads 0 in the idle state and 1 in the alarm state. The qualification counter never reaches `QUAL_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sense | input | 3 | Bit 2 arms the system; bits 1 and 0 are the sensors |
| siren | output | 1 | Siren drive, 1 = sounding |
| alarm_state | output | 1 | State indicator, 0 = idle, 1 = alarm |

## Verification
Two things can coincide in the same cycle. One is the final cycle of the qualification count. The other is the qualifying condition dropping, either because the input changes or because reset asserts. The bench provokes both cases. It holds a triggering or disarming input for exactly `QUAL_CYC`−1 cycles before withdrawing it, and it also asserts reset while the counter is near its limit. Both outputs are then compared every cycle against a cycle-level model built from the requirements. With these provocations, an off-by-one in the counter, or a missed counter clear, shows up as a transition one cycle early or a transition that should not happen at all.

// File: rtl/door_alarm_pkg.sv
package door_alarm_pkg;
  localparam int SENSE_W = 3;
  localparam int ARM_IDX = 2;
  typedef enum logic {ST_IDLE = 1'b0, ST_ALARM = 1'b1} alarm_state_e;
endpackage

// File: rtl/dalm_in_stage.sv
module dalm_in_stage #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/dalm_qualify.sv
module dalm_qualify #(
  parameter int QUAL_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic fire
);
  localparam int CW = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;

  assign fire = cond && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b1;
    cnt_nx = cnt_q + 1'b1;
    if (!cond || fire) cnt_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  // R8: counter stays below the window length
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < QUAL_CYC);
  // R5: a dropped condition restarts qualification
  a_r5_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> cnt_q == '0);
endmodule

// File: rtl/dalm_fsm.sv
module dalm_fsm
  import door_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SENSE_W-1:0] sense_q,
  input  logic               fire,
  output logic               cond,
  output alarm_state_e       state_q,
  output alarm_state_e       state_nx
);
  logic armed, tripped;

  assign armed   = sense_q[ARM_IDX];
  assign tripped = |sense_q[ARM_IDX-1:0];

  always_comb begin
    cond     = 1'b0;
    state_nx = state_q;
    unique case (state_q)
      ST_IDLE: begin
        cond = armed && tripped;
        if (fire) state_nx = ST_ALARM;
      end
      ST_ALARM: begin
        cond = !armed;
        if (fire) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nx;
  end

  // R4: entering alarm needs armed plus a tripped sensor
  a_r4_entry_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ALARM && $past(state_q) == ST_IDLE) |->
      ($past(sense_q[ARM_IDX]) && $past(|sense_q[ARM_IDX-1:0])));
  // R6 / R7: leaving alarm needs the arming bit cleared
  a_r7_exit_needs_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && $past(state_q) == ST_ALARM) |-> !$past(sense_q[ARM_IDX]));
endmodule

// File: rtl/door_alarm_ctrl.sv
module door_alarm_ctrl
  import door_alarm_pkg::*;
#(
  parameter int QUAL_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sense,
  output logic       siren,
  output logic       alarm_state
);
  logic [SENSE_W-1:0] sense_q;
  logic               cond, fire;
  alarm_state_e       st_q, st_nx;
  logic               siren_q;

  dalm_in_stage #(.W(SENSE_W)) u_in (
    .clk(clk), .rst_n(rst_n), .d(sense), .q(sense_q));

  dalm_qualify #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .cond(cond), .fire(fire));

  dalm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sense_q(sense_q), .fire(fire),
    .cond(cond), .state_q(st_q), .state_nx(st_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) siren_q <= 1'b0;
    else        siren_q <= (st_nx == ST_ALARM);
  end

  assign siren       = siren_q;
  assign alarm_state = st_q;

  // R2: siren register tracks the state register
  a_r2_siren_tracks_state: assert property (@(posedge clk) disable iff (!rst_n)
    siren == alarm_state);
  // R1: reset state
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!siren && !alarm_state));
endmodule

// File: tb/tb_door_alarm_ctrl.sv
`timescale 1ns/100ps
module tb_door_alarm_ctrl;
  localparam int QN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sense = 3'b000;
  logic       siren, alarm_state;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit auto_on = 0;

  door_alarm_ctrl #(.QUAL_CYC(QN)) dut (
    .clk(clk), .rst_n(rst_n), .sense(sense),
    .siren(siren), .alarm_state(alarm_state));

  always #2.5 clk = ~clk;

  // cycle model built from the requirements
  logic [2:0] m_in;
  logic       m_st;
  int         m_run;

  function automatic bit qual(input logic st, input logic [2:0] v);
    return st ? !v[2] : (v[2] && (v[1] | v[0]));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in = 3'b000; m_st = 1'b0; m_run = 0;
    end else begin
      if (qual(m_st, m_in)) begin
        if (m_run == QN - 1) begin m_st = ~m_st; m_run = 0; end
        else m_run = m_run + 1;
      end else m_run = 0;
      m_in = sense;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // R2 / R8: every cycle against the model
  always @(negedge clk) begin
    if (auto_on && rst_n) begin
      check("R8", alarm_state, m_st);
      check("R2", siren, m_st);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    cycles(2);
    check("R1", alarm_state, 1'b0);
    check("R1", siren, 1'b0);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", alarm_state, 1'b0);
    check("R1", siren, 1'b0);
  endtask

  task automatic apply_and_expect(input logic [2:0] v, input logic from_st, input string tag);
    @(negedge clk) sense = v;
    cycles(QN);
    check(tag, alarm_state, from_st);
    @(negedge clk);
    check(tag, alarm_state, ~from_st);
    check(tag, siren, ~from_st);
  endtask

  initial begin
    #0.1;
    do_reset();
    auto_on = 1;
    // R3: non-qualifying values keep idle
    for (int v = 0; v <= 4; v++) begin
      @(negedge clk) sense = 3'(v);
      cycles(3 * QN);
      check("R3", alarm_state, 1'b0);
      check("R3", siren, 1'b0);
    end
    // R4: trigger on 101 at exactly QN+1 edges
    apply_and_expect(3'b101, 1'b0, "R4");
    // R6: sensors at rest but still armed
    @(negedge clk) sense = 3'b100;
    cycles(3 * QN);
    check("R6", alarm_state, 1'b1);
    check("R6", siren, 1'b1);
    @(negedge clk) sense = 3'b111;
    cycles(QN);
    check("R6", alarm_state, 1'b1);
    // R5: disarm held QN-1 cycles then rearmed -> stays alarm
    @(negedge clk) sense = 3'b001;
    cycles(QN - 1);
    sense = 3'b100;
    cycles(2 * QN);
    check("R5", alarm_state, 1'b1);
    // R7: disarm
    apply_and_expect(3'b001, 1'b1, "R7");
    // R5: trigger held QN-1 cycles then released -> stays idle
    @(negedge clk) sense = 3'b110;
    cycles(QN - 1);
    sense = 3'b100;
    cycles(2 * QN);
    check("R5", alarm_state, 1'b0);
    // R4 with 110, R7 with 000
    apply_and_expect(3'b110, 1'b0, "R4");
    apply_and_expect(3'b000, 1'b1, "R7");
    // R1: reset near counter limit
    @(negedge clk) sense = 3'b111;
    cycles(QN - 1);
    auto_on = 0;
    do_reset();
    auto_on = 1;
    sense = 3'b000;
    cycles(2 * QN);
    check("R1", alarm_state, 1'b0);
    // random bursts, fixed seed
    void'($urandom(32'h5eed_0a1a));
    for (int i = 0; i < 600; i++) begin
      @(negedge clk) sense = 3'($urandom_range(0, 7));
      cycles($urandom_range(1, QN + 4));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule